// File: doc/BRIEF.md
# Startup Status and Global Override Controller

This block sequences the end of a device's configuration and then guards its user-facing outputs and registers. It runs from a configuration-reset input and a stream of received configuration frames. Each frame arrives as a valid strobe with a last-frame marker and a one-bit status-enable option flag. Frame content decoding is not part of the block. The block drives an open-drain "initialization done" pad as an enable/data pair. The pad is released while reset is held and before the first frame. It is pulled low once the first frame has enabled it, and it is released again when the device enters user mode. The rising edge that an external pull-up produces on that pad therefore marks completion.

Initialization takes a parameterised number of ticks after the last frame. A tick is either a cycle of the block clock or a rising edge of a user-supplied clock, selected by a parameter. An optional gate holds completion back until an I/O calibration-done input is high. After completion, two active-low global controls act on the user side. One forces every user output enable off, giving high impedance. The other holds every user register cleared. Before user mode, all user outputs are tri-stated and all user registers are cleared.

The sequencer states are `ST_RESET`, `ST_WAIT_FRAME`, `ST_LOAD`, `ST_INIT`, `ST_CAL_WAIT` and `ST_USER`. Its transitions are:
- Reset low in any state goes to `ST_RESET`.
- `ST_RESET` goes to `ST_WAIT_FRAME` on the first clock with reset high.
- In `ST_WAIT_FRAME`, a frame goes to `ST_LOAD`, or to `ST_INIT` when that frame is also the last one.
- `ST_LOAD` goes to `ST_INIT` when the last frame is accepted.
- `ST_INIT` goes to `ST_USER` on the final tick when the gate is satisfied, and otherwise to `ST_CAL_WAIT`.
- `ST_CAL_WAIT` goes to `ST_USER` when calibration-done is high.
- `ST_USER` is left only through reset.

Top module: `cfg_startup_ctrl`

## Requirements
- R1: While `cfg_rst_n` is low, `done_pad_oe`, `user_mode`, every `pad_oe` bit and every `ureg_q` bit are 0.
- R2: After reset, `done_pad_oe` stays 0 until the first frame is accepted. If that frame has `frame_opt`=1, `done_pad_oe` is 1 from the cycle after the frame is accepted until completion.
- R3: `done_pad_o` is always 0, so the status pad is only ever pulled low or released.
- R4: With the block clock as tick source, `user_mode` rises and `done_pad_oe` falls exactly INIT_CYCLES clock edges after the edge that accepts the last frame, provided the calibration gate is satisfied.
- R5: If the first frame has `frame_opt`=0, `done_pad_oe` stays 0 for the whole sequence, including when a later frame carries `frame_opt`=1, and `user_mode` still rises at completion.
- R6: With USE_CAL_GATE=1, completion waits while `cal_done` is 0. In that wait, `done_pad_oe` stays 1. `user_mode` rises on the first edge that samples `cal_done`=1.
- R7: With USE_CAL_GATE=0, `cal_done` has no effect on completion.
- R8: With USE_USER_CLK=1, only rising edges of `user_clk` advance initialization. These edges reach the counter through a two-stage synchronizer. Without `user_clk` edges the block stays uncompleted.
- R9: `cfg_rst_n` going low at any time, including in user mode, at once returns the block to reset, releases the status pad and clears `user_mode`.
- R10: In user mode, `pad_oe` equals `core_oe` while `ovr_oe_allow` is 1 and is all zero while it is 0. `pad_out` follows `core_out`.
- R11: In user mode, `ureg_q` loads `core_d` on each clock edge while `ovr_clr_n` is 1. After each edge that samples `ovr_clr_n`=0, `ureg_q` is 0.
- R12: Before user mode, every `pad_oe` bit and every `ureg_q` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| cfg_rst_n | input | 1 | Configuration reset, active low, asynchronous abort |
| frame_valid | input | 1 | One configuration frame accepted this cycle |
| frame_last | input | 1 | Accepted frame is the final one |
| frame_opt | input | 1 | Status-enable option flag carried by the frame (used from the first frame only) |
| cal_done | input | 1 | I/O calibration finished |
| user_clk | input | 1 | Optional user-supplied initialization clock |
| ovr_oe_allow | input | 1 | Global output enable, low forces all user outputs to high impedance |
| ovr_clr_n | input | 1 | Global register clear, low holds all user registers at 0 |
| core_out | input | IO_W | User output data |
| core_oe | input | IO_W | User output enables |
| core_d | input | REG_W | User register inputs |
| pad_out | output | IO_W | Output data to pads |
| pad_oe | output | IO_W | Gated output enables to pads |
| ureg_q | output | REG_W | User register outputs |
| done_pad_o | output | 1 | Status pad data (constant low) |
| done_pad_oe | output | 1 | Status pad enable, 1 pulls the pad low |
| user_mode | output | 1 | Device is in user mode |

## Verification
The assertions assume that `frame_valid`, `frame_last`, `frame_opt` and `cal_done` are synchronous to `clk`. They also assume that `user_clk` stays at each level for at least three block clock cycles, so that every one of its rising edges becomes exactly one tick. The stimulus changes all inputs on the falling clock edge. It holds `user_clk` at each level for four block cycles. It raises frames only while the sequencer can accept them, and it toggles `cfg_rst_n` only between scenarios or as a deliberate abort.

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;

    typedef enum logic [2:0] {
        ST_RESET      = 3'd0,
        ST_WAIT_FRAME = 3'd1,
        ST_LOAD       = 3'd2,
        ST_INIT       = 3'd3,
        ST_CAL_WAIT   = 3'd4,
        ST_USER       = 3'd5
    } cfg_state_e;

endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
    parameter int USE_USER_CLK = 0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic user_clk,
    output logic tick
);

    localparam int HIST_W = SYNC_STAGES + 1;

    logic [HIST_W-1:0] hist_q;
    logic              uclk_rise;

    // synchronizer stages plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST_W-2:0], user_clk};
        end
    end

    assign uclk_rise = hist_q[HIST_W-2] & ~hist_q[HIST_W-1];
    assign tick      = (USE_USER_CLK != 0) ? uclk_rise : 1'b1;

    generate
        if (USE_USER_CLK != 0) begin : g_uclk_chk
            // R8: a user clock edge yields a single tick
            p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("p_tick_single_r8");
        end
    endgenerate

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_startup_pkg::*;
#(
    parameter int INIT_CYCLES  = 8,
    parameter int USE_CAL_GATE = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid,
    input  logic frame_last,
    input  logic frame_opt,
    input  logic cal_done,
    input  logic tick,
    output logic done_oe,
    output logic user_mode
);

    localparam int             CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(INIT_CYCLES - 1);

    cfg_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             opt_q;
    logic             cal_ok;

    assign cal_ok = (USE_CAL_GATE != 0) ? cal_done : 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_nx;
        end
    end

    // next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RESET:      state_nx = ST_WAIT_FRAME;
            ST_WAIT_FRAME: if (frame_valid) state_nx = frame_last ? ST_INIT : ST_LOAD;
            ST_LOAD:       if (frame_valid && frame_last) state_nx = ST_INIT;
            ST_INIT:       if (tick && (cnt_q == LAST_CNT))
                               state_nx = cal_ok ? ST_USER : ST_CAL_WAIT;
            ST_CAL_WAIT:   if (cal_ok) state_nx = ST_USER;
            ST_USER:       state_nx = ST_USER;
            default:       state_nx = ST_RESET;
        endcase
    end

    // initialization tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != ST_INIT) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // status-enable option latched from the first frame only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q <= 1'b0;
        end else if (state_q == ST_WAIT_FRAME && frame_valid) begin
            opt_q <= frame_opt;
        end
    end

    // outputs
    always_comb begin
        done_oe   = 1'b0;
        user_mode = 1'b0;
        unique case (state_q)
            ST_LOAD, ST_INIT, ST_CAL_WAIT: done_oe = opt_q;
            ST_USER:                       user_mode = 1'b1;
            default: begin
                done_oe   = 1'b0;
                user_mode = 1'b0;
            end
        endcase
    end

    // R2: an enabling first frame pulls the pad low on the next cycle
    p_first_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_FRAME && frame_valid && frame_opt) |=> done_oe)
        else $error("p_first_frame_r2");

    // R8: counter only moves on a tick
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && !tick) |=> $stable(cnt_q))
        else $error("p_cnt_hold_r8");

    // R4: counter never runs past the programmed length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(INIT_CYCLES))
        else $error("p_cnt_bound_r4");

    // R9: user mode is left only through reset
    p_user_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |=> user_mode)
        else $error("p_user_sticky_r9");

    generate
        if (USE_CAL_GATE != 0) begin : g_cal_chk
            // R6: no completion while calibration is pending
            p_cal_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_CAL_WAIT && !cal_done) |=> !user_mode)
                else $error("p_cal_gate_r6");
        end
    endgenerate

endmodule

// File: rtl/cfg_io_override.sv
module cfg_io_override #(
    parameter int IO_W       = 8,
    parameter int REG_W      = 8,
    parameter int OE_OVR_EN  = 1,
    parameter int CLR_OVR_EN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             user_mode,
    input  logic             ovr_oe_allow,
    input  logic             ovr_clr_n,
    input  logic [IO_W-1:0]  core_out,
    input  logic [IO_W-1:0]  core_oe,
    input  logic [REG_W-1:0] core_d,
    output logic [IO_W-1:0]  pad_out,
    output logic [IO_W-1:0]  pad_oe,
    output logic [REG_W-1:0] ureg_q
);

    logic oe_ok;
    logic clr_ok;

    assign oe_ok  = (OE_OVR_EN  == 0) ? 1'b1 : ovr_oe_allow;
    assign clr_ok = (CLR_OVR_EN == 0) ? 1'b1 : ovr_clr_n;

    generate
        for (genvar i = 0; i < IO_W; i++) begin : g_io
            assign pad_out[i] = core_out[i];
            assign pad_oe[i]  = user_mode & oe_ok & core_oe[i];
        end

        for (genvar j = 0; j < REG_W; j++) begin : g_reg
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (!user_mode || !clr_ok) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= core_d[j];
                end
            end
            assign ureg_q[j] = bit_q;
        end

        if (CLR_OVR_EN != 0) begin : g_clr_chk
            // R11: a sampled global clear leaves every register at zero
            p_clear_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !ovr_clr_n |=> (ureg_q == '0))
                else $error("p_clear_hold_r11");
        end
    endgenerate

    // R12: registers stay cleared while not in user mode
    p_regs_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |=> (ureg_q == '0) || user_mode)
        else $error("p_regs_idle_r12");

endmodule

// File: rtl/cfg_startup_ctrl.sv
module cfg_startup_ctrl #(
    parameter int IO_W         = 8,
    parameter int REG_W        = 8,
    parameter int INIT_CYCLES  = 8,
    parameter int USE_CAL_GATE = 1,
    parameter int USE_USER_CLK = 0,
    parameter int OE_OVR_EN    = 1,
    parameter int CLR_OVR_EN   = 1
) (
    input  logic             clk,
    input  logic             cfg_rst_n,
    input  logic             frame_valid,
    input  logic             frame_last,
    input  logic             frame_opt,
    input  logic             cal_done,
    input  logic             user_clk,
    input  logic             ovr_oe_allow,
    input  logic             ovr_clr_n,
    input  logic [IO_W-1:0]  core_out,
    input  logic [IO_W-1:0]  core_oe,
    input  logic [REG_W-1:0] core_d,
    output logic [IO_W-1:0]  pad_out,
    output logic [IO_W-1:0]  pad_oe,
    output logic [REG_W-1:0] ureg_q,
    output logic             done_pad_o,
    output logic             done_pad_oe,
    output logic             user_mode
);

    logic tick;

    cfg_tick_gen #(
        .USE_USER_CLK (USE_USER_CLK),
        .SYNC_STAGES  (2)
    ) u_tick (
        .clk      (clk),
        .rst_n    (cfg_rst_n),
        .user_clk (user_clk),
        .tick     (tick)
    );

    cfg_seq_fsm #(
        .INIT_CYCLES  (INIT_CYCLES),
        .USE_CAL_GATE (USE_CAL_GATE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (cfg_rst_n),
        .frame_valid (frame_valid),
        .frame_last  (frame_last),
        .frame_opt   (frame_opt),
        .cal_done    (cal_done),
        .tick        (tick),
        .done_oe     (done_pad_oe),
        .user_mode   (user_mode)
    );

    cfg_io_override #(
        .IO_W       (IO_W),
        .REG_W      (REG_W),
        .OE_OVR_EN  (OE_OVR_EN),
        .CLR_OVR_EN (CLR_OVR_EN)
    ) u_ovr (
        .clk          (clk),
        .rst_n        (cfg_rst_n),
        .user_mode    (user_mode),
        .ovr_oe_allow (ovr_oe_allow),
        .ovr_clr_n    (ovr_clr_n),
        .core_out     (core_out),
        .core_oe      (core_oe),
        .core_d       (core_d),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .ureg_q       (ureg_q)
    );

    // open-drain status pad: data is tied low, only the enable moves
    assign done_pad_o = 1'b0;

    // R4: entering user mode coincides with releasing the status pad
    p_release_at_user_r4: assert property (@(posedge clk) disable iff (!cfg_rst_n)
        $rose(user_mode) |-> !done_pad_oe)
        else $error("p_release_at_user_r4");

endmodule

// File: tb/tb_cfg_startup_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_startup_ctrl;

    localparam int IO_W  = 8;
    localparam int REG_W = 8;
    localparam int INIT  = 8;

    logic             clk = 1'b0;
    logic             cfg_rst_n = 1'b0;
    logic             frame_valid = 1'b0;
    logic             frame_last = 1'b0;
    logic             frame_opt = 1'b0;
    logic             cal_done = 1'b1;
    logic             user_clk = 1'b0;
    logic             ovr_oe_allow = 1'b1;
    logic             ovr_clr_n = 1'b1;
    logic [IO_W-1:0]  core_out = '0;
    logic [IO_W-1:0]  core_oe = '1;
    logic [REG_W-1:0] core_d = '0;

    logic [IO_W-1:0]  pad_out, pad_oe, uc_pad_out, uc_pad_oe;
    logic [REG_W-1:0] ureg_q, uc_ureg_q;
    logic             done_pad_o, done_pad_oe, user_mode;
    logic             uc_done_o, uc_done_oe, uc_user_mode;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_startup_ctrl #(.IO_W(IO_W), .REG_W(REG_W), .INIT_CYCLES(INIT),
                       .USE_CAL_GATE(1), .USE_USER_CLK(0)) dut (
        .clk(clk), .cfg_rst_n(cfg_rst_n), .frame_valid(frame_valid),
        .frame_last(frame_last), .frame_opt(frame_opt), .cal_done(cal_done),
        .user_clk(user_clk), .ovr_oe_allow(ovr_oe_allow), .ovr_clr_n(ovr_clr_n),
        .core_out(core_out), .core_oe(core_oe), .core_d(core_d),
        .pad_out(pad_out), .pad_oe(pad_oe), .ureg_q(ureg_q),
        .done_pad_o(done_pad_o), .done_pad_oe(done_pad_oe), .user_mode(user_mode));

    cfg_startup_ctrl #(.IO_W(IO_W), .REG_W(REG_W), .INIT_CYCLES(INIT),
                       .USE_CAL_GATE(0), .USE_USER_CLK(1)) dut_uc (
        .clk(clk), .cfg_rst_n(cfg_rst_n), .frame_valid(frame_valid),
        .frame_last(frame_last), .frame_opt(frame_opt), .cal_done(cal_done),
        .user_clk(user_clk), .ovr_oe_allow(ovr_oe_allow), .ovr_clr_n(ovr_clr_n),
        .core_out(core_out), .core_oe(core_oe), .core_d(core_d),
        .pad_out(uc_pad_out), .pad_oe(uc_pad_oe), .ureg_q(uc_ureg_q),
        .done_pad_o(uc_done_o), .done_pad_oe(uc_done_oe), .user_mode(uc_user_mode));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        cfg_rst_n   = 1'b0;
        frame_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "done_pad_oe in reset", 32'(done_pad_oe), 0);
        chk("R1", "user_mode in reset", 32'(user_mode), 0);
        chk("R1", "pad_oe in reset", 32'(pad_oe), 0);
        chk("R1", "ureg_q in reset", 32'(ureg_q), 0);
        cfg_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic opt, input logic last);
        frame_opt   = opt;
        frame_last  = last;
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        frame_last  = 1'b0;
        frame_opt   = 1'b0;
    endtask

    task automatic t_normal();
        cal_done = 1'b1;
        core_oe  = '1;
        do_reset();
        chk("R2", "released before first frame", 32'(done_pad_oe), 0);
        send(1'b1, 1'b0);
        chk("R2", "pulled low after enabling frame", 32'(done_pad_oe), 1);
        chk("R12", "pad_oe during load", 32'(pad_oe), 0);
        send(1'b0, 1'b0);
        send(1'b0, 1'b1);
        chk("R2", "still low after last frame", 32'(done_pad_oe), 1);
        repeat (INIT - 1) @(negedge clk);
        chk("R4", "user_mode one edge early", 32'(user_mode), 0);
        chk("R4", "done_pad_oe one edge early", 32'(done_pad_oe), 1);
        chk("R12", "ureg_q before user mode", 32'(ureg_q), 0);
        @(negedge clk);
        chk("R4", "user_mode at completion", 32'(user_mode), 1);
        chk("R4", "pad released at completion", 32'(done_pad_oe), 0);
        chk("R3", "status data low", 32'(done_pad_o), 0);
        chk("R10", "pad_oe follows core_oe", 32'(pad_oe), 32'hFF);
    endtask

    task automatic t_no_opt();
        cal_done = 1'b1;
        do_reset();
        send(1'b0, 1'b0);
        chk("R5", "no pull without option", 32'(done_pad_oe), 0);
        send(1'b1, 1'b0);
        chk("R5", "later option flag ignored", 32'(done_pad_oe), 0);
        send(1'b0, 1'b1);
        repeat (INIT - 1) @(negedge clk);
        chk("R5", "still released in init", 32'(done_pad_oe), 0);
        @(negedge clk);
        chk("R5", "user_mode without option", 32'(user_mode), 1);
    endtask

    task automatic t_cal_gate();
        cal_done = 1'b0;
        do_reset();
        send(1'b1, 1'b1);
        repeat (INIT + 5) @(negedge clk);
        chk("R6", "held while calibrating", 32'(user_mode), 0);
        chk("R6", "pad low while calibrating", 32'(done_pad_oe), 1);
        cal_done = 1'b1;
        @(negedge clk);
        chk("R6", "user_mode after cal_done", 32'(user_mode), 1);
        chk("R6", "pad released after cal_done", 32'(done_pad_oe), 0);
    endtask

    task automatic t_overrides();
        core_oe      = 8'hA5;
        core_out     = 8'h3C;
        ovr_oe_allow = 1'b1;
        #1;
        chk("R10", "pad_oe passes", 32'(pad_oe), 32'hA5);
        chk("R10", "pad_out passes", 32'(pad_out), 32'h3C);
        ovr_oe_allow = 1'b0;
        #1;
        chk("R10", "pad_oe forced off", 32'(pad_oe), 0);
        ovr_oe_allow = 1'b1;
        core_d = 8'h96;
        @(negedge clk);
        chk("R11", "register loads", 32'(ureg_q), 32'h96);
        ovr_clr_n = 1'b0;
        core_d    = 8'h5A;
        @(negedge clk);
        chk("R11", "cleared by override", 32'(ureg_q), 0);
        @(negedge clk);
        chk("R11", "held cleared", 32'(ureg_q), 0);
        ovr_clr_n = 1'b1;
        @(negedge clk);
        chk("R11", "loads after override", 32'(ureg_q), 32'h5A);
    endtask

    task automatic t_abort();
        cfg_rst_n = 1'b0;
        #1;
        chk("R9", "user_mode aborted", 32'(user_mode), 0);
        chk("R9", "pad released on abort", 32'(done_pad_oe), 0);
        chk("R9", "registers cleared on abort", 32'(ureg_q), 0);
        @(negedge clk);
        cfg_rst_n = 1'b1;
        cal_done  = 1'b1;
        @(negedge clk);
        send(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk("R9", "pulled low mid init", 32'(done_pad_oe), 1);
        cfg_rst_n = 1'b0;
        #1;
        chk("R9", "released on abort mid init", 32'(done_pad_oe), 0);
        @(negedge clk);
        cfg_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_uclk();
        cal_done = 1'b0;
        user_clk = 1'b0;
        do_reset();
        send(1'b1, 1'b1);
        repeat (20) @(negedge clk);
        chk("R8", "no progress without user clock", 32'(uc_user_mode), 0);
        chk("R8", "pad low awaiting user clock", 32'(uc_done_oe), 1);
        for (int k = 0; k < INIT - 1; k++) begin
            user_clk = 1'b1;
            repeat (4) @(negedge clk);
            user_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        chk("R8", "one user edge short", 32'(uc_user_mode), 0);
        user_clk = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8", "completes on last user edge", 32'(uc_user_mode), 1);
        chk("R7", "cal_done low ignored", 32'(uc_done_oe), 0);
        user_clk = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_normal();
        t_overrides();
        t_abort();
        t_no_opt();
        t_cal_gate();
        t_uclk();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule